// File: doc/BRIEF.md
# UART Receive Software Flow-Control Detector

This block sits between the byte output of a UART receiver and its receive FIFO. It inspects every completed character and applies in-band software flow control. A character that matches the programmed "stop sending" code (Xoff) raises a transmit-halt flag for the local transmitter. A character that matches the "resume" code (Xon) lowers that flag. Recognised flow-control characters are removed from the stream instead of being written to the FIFO. A 4-bit control field selects how matching works:
- off,
- a single Xon/Xoff pair,
- either of two pairs,
- a two-byte sequence made of both pairs.

A separate enable adds special-character detection against the second Xoff register. It produces an interrupt pulse and a sticky status bit.

The byte path is a valid/ready stream with a passthrough back-pressure rule:
- `in_ready` always equals `out_ready`, so a byte is accepted only in a cycle where `in_valid` and `in_ready` are both high.
- `out_valid` follows `in_valid` unless the byte is being dropped as a flow-control character. `out_data` always carries `in_data`.
- A byte that is presented but not accepted changes no state and raises no interrupt.

Top module: `uart_rx_swflow`

## Requirements
- R1: After reset, `tx_halt` and `spec_status` are 0.
- R2: `in_ready` equals `out_ready`. `out_data` equals `in_data`. `out_valid` is `in_valid` with flow-control characters removed. Bytes that are not accepted change no state and raise no interrupt.
- R3: With `flow_ctrl[1:0]`=10, the character `xon1_chr` is the Xon code and `xoff1_chr` is the Xoff code.
- R4: With `flow_ctrl[1:0]`=01, the character `xon2_chr` is the Xon code and `xoff2_chr` is the Xoff code.
- R5: With `flow_ctrl` = 1011 or 0111 (bit 3 first), either Xon register counts as Xon and either Xoff register counts as Xoff.
- R6: With `flow_ctrl` = 0011 or 1111, Xoff is recognised only on an accepted `xoff2_chr` that directly follows an accepted `xoff1_chr`, and Xon likewise only on `xon2_chr` directly after `xon1_chr`. The first byte of such a pair is written to the FIFO. Any other byte in between restarts the match.
- R7: With `flow_ctrl[1:0]`=00, no character is dropped, no Xoff interrupt fires, and `tx_halt` is 0 from the next cycle on.
- R8: An accepted, recognised Xoff sets `tx_halt` on the next clock edge. A recognised Xon clears it. If a byte matches both, Xoff wins.
- R9: A recognised flow-control character has `out_valid` low. `xoff_irq` pulses in the cycle an Xoff is accepted.
- R10: With `spec_en`=1, an accepted byte equal to `xoff2_chr` (bit 0 matched to the byte's LSB) pulses `spec_irq` in the same cycle and sets `spec_status` at the next edge. The byte is still written unless it is a recognised flow-control character.
- R11: With `spec_en`=1 and `flow_ctrl[1:0]`=01, an accepted `xoff2_chr` is dropped and pulses both `xoff_irq` and `spec_irq`.
- R12: `spec_status` stays set until a `status_clr` pulse. A new detection in the same cycle as the clear wins.
- R13: With `spec_en`=0, `spec_irq` never fires and `spec_status` is never set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flow_ctrl | input | 4 | [3:2] transmit character select, [1:0] receive match select |
| spec_en | input | 1 | Special-character detection enable |
| xon1_chr | input | 8 | First Xon character |
| xon2_chr | input | 8 | Second Xon character |
| xoff1_chr | input | 8 | First Xoff character |
| xoff2_chr | input | 8 | Second Xoff character, also the special character |
| in_valid | input | 1 | Received byte valid |
| in_ready | output | 1 | Byte can be taken (equals `out_ready`) |
| in_data | input | 8 | Received byte |
| out_valid | output | 1 | Byte to be written to the receive FIFO |
| out_ready | input | 1 | FIFO has room |
| out_data | output | 8 | Byte to the FIFO |
| tx_halt | output | 1 | Local transmitter must pause |
| xoff_irq | output | 1 | Single-cycle Xoff detected pulse |
| spec_irq | output | 1 | Single-cycle special-character pulse |
| spec_status | output | 1 | Sticky special-character status |
| status_clr | input | 1 | Clears `spec_status` |

## Verification
The following are combinational in the cycle the byte is presented, so the bench samples them one time unit after driving inputs on the falling edge:
- `out_valid`, `out_data`, `in_ready`,
- `xoff_irq` and `spec_irq`.

`tx_halt` and `spec_status` each pass through one register, so they are checked at the next falling edge, after exactly one rising edge. The sweep covers all 16 control codes with both values of `spec_en`. Each code receives every ordered pair of the four programmed characters plus a neutral byte, with stalls, idle cycles and status clears interleaved. A bench model built from the requirements supplies each expected value at that same point.

// File: rtl/uart_rx_swflow_pkg.sv
package uart_rx_swflow_pkg;

  typedef enum logic [2:0] {
    RXM_OFF   = 3'd0,
    RXM_ONE   = 3'd1,
    RXM_TWO   = 3'd2,
    RXM_ANY   = 3'd3,
    RXM_SEQ   = 3'd4
  } rx_match_e;

  // Receive bits [1:0]; with both set, transmit bits [3:2] pick either-of vs sequence.
  function automatic rx_match_e decode_mode(input logic [3:0] ctl);
    rx_match_e m;
    unique case (ctl[1:0])
      2'b00: m = RXM_OFF;
      2'b10: m = RXM_ONE;
      2'b01: m = RXM_TWO;
      default: m = (ctl[3] ^ ctl[2]) ? RXM_ANY : RXM_SEQ;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/uart_rx_swflow_match.sv
module uart_rx_swflow_match
  import uart_rx_swflow_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  rx_match_e     mode,
  input  logic          acc,
  input  logic [DW-1:0] din,
  input  logic [DW-1:0] on1,
  input  logic [DW-1:0] on2,
  input  logic [DW-1:0] off1,
  input  logic [DW-1:0] off2,
  output logic          off_hit,
  output logic          on_hit
);

  logic eq_on1, eq_on2, eq_off1, eq_off2;
  logic pend_off, pend_on;

  assign eq_on1  = (din == on1);
  assign eq_on2  = (din == on2);
  assign eq_off1 = (din == off1);
  assign eq_off2 = (din == off2);

  always_comb begin
    off_hit = 1'b0;
    on_hit  = 1'b0;
    unique case (mode)
      RXM_ONE: begin off_hit = eq_off1; on_hit = eq_on1; end
      RXM_TWO: begin off_hit = eq_off2; on_hit = eq_on2; end
      RXM_ANY: begin off_hit = eq_off1 | eq_off2; on_hit = eq_on1 | eq_on2; end
      RXM_SEQ: begin off_hit = pend_off & eq_off2; on_hit = pend_on & eq_on2; end
      default: ;
    endcase
  end

  // Memory of the previous accepted byte for two-byte sequence matching.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_off <= 1'b0;
      pend_on  <= 1'b0;
    end else if (mode != RXM_SEQ) begin
      pend_off <= 1'b0;
      pend_on  <= 1'b0;
    end else if (acc) begin
      pend_off <= eq_off1;
      pend_on  <= eq_on1;
    end
  end

  a_r6_seq_off_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == RXM_SEQ && off_hit) |-> pend_off);

  a_r7_off_mode_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == RXM_OFF) |-> (!off_hit && !on_hit));

endmodule

// File: rtl/uart_rx_swflow_flags.sv
module uart_rx_swflow_flags
  import uart_rx_swflow_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  rx_match_e mode,
  input  logic      acc,
  input  logic      off_hit,
  input  logic      on_hit,
  input  logic      spec_hit,
  input  logic      clr,
  output logic      halt,
  output logic      stat
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt <= 1'b0;
    end else if (mode == RXM_OFF) begin
      halt <= 1'b0;
    end else if (acc && off_hit) begin
      halt <= 1'b1;
    end else if (acc && on_hit) begin
      halt <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                stat <= 1'b0;
    else if (acc && spec_hit)  stat <= 1'b1;
    else if (clr)              stat <= 1'b0;
  end

  a_r8_halt_set: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && off_hit && mode != RXM_OFF) |=> halt);

  a_r8_halt_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && on_hit && !off_hit) |=> !halt);

  a_r7_halt_forced_low: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == RXM_OFF) |=> !halt);

  a_r12_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (stat && !clr) |=> stat);

  a_r10_status_set: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && spec_hit) |=> stat);

endmodule

// File: rtl/uart_rx_swflow.sv
module uart_rx_swflow
  import uart_rx_swflow_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    flow_ctrl,
  input  logic          spec_en,
  input  logic [DW-1:0] xon1_chr,
  input  logic [DW-1:0] xon2_chr,
  input  logic [DW-1:0] xoff1_chr,
  input  logic [DW-1:0] xoff2_chr,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          tx_halt,
  output logic          xoff_irq,
  output logic          spec_irq,
  output logic          spec_status,
  input  logic          status_clr
);

  rx_match_e mode;
  logic      acc, off_hit, on_hit, spec_hit, drop;

  assign mode     = decode_mode(flow_ctrl);
  assign in_ready = out_ready;
  assign acc      = in_valid & out_ready;
  assign spec_hit = spec_en & (in_data == xoff2_chr);
  assign drop     = off_hit | on_hit;

  assign out_valid = in_valid & ~drop;
  assign out_data  = in_data;
  assign xoff_irq  = acc & off_hit;
  assign spec_irq  = acc & spec_hit;

  uart_rx_swflow_match #(.DW(DW)) u_match (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode),
    .acc     (acc),
    .din     (in_data),
    .on1     (xon1_chr),
    .on2     (xon2_chr),
    .off1    (xoff1_chr),
    .off2    (xoff2_chr),
    .off_hit (off_hit),
    .on_hit  (on_hit)
  );

  uart_rx_swflow_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .acc      (acc),
    .off_hit  (off_hit),
    .on_hit   (on_hit),
    .spec_hit (spec_hit),
    .clr      (status_clr),
    .halt     (tx_halt),
    .stat     (spec_status)
  );

  a_r9_xoff_not_written: assert property (@(posedge clk) disable iff (!rst_n)
    xoff_irq |-> !out_valid);

  a_r13_no_spec_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !spec_en |-> !spec_irq);

  a_r2_irq_needs_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (xoff_irq || spec_irq) |-> (in_valid && in_ready));

endmodule

// File: tb/tb_uart_rx_swflow.sv
module tb_uart_rx_swflow;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] C_ON1 = 8'h11, C_ON2 = 8'h12, C_OFF1 = 8'h13, C_OFF2 = 8'h93, C_OTH = 8'h41;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] flow_ctrl = 4'd0;
  logic spec_en = 1'b0, in_valid = 1'b0, out_ready = 1'b0, status_clr = 1'b0;
  logic [7:0] in_data = 8'd0;
  logic in_ready, out_valid, tx_halt, xoff_irq, spec_irq, spec_status;
  logic [7:0] out_data;

  int n_chk = 0, n_bad = 0;
  bit m_halt = 0, m_stat = 0, m_poff = 0, m_pon = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_rx_swflow dut (
    .clk(clk), .rst_n(rst_n), .flow_ctrl(flow_ctrl), .spec_en(spec_en),
    .xon1_chr(C_ON1), .xon2_chr(C_ON2), .xoff1_chr(C_OFF1), .xoff2_chr(C_OFF2),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .tx_halt(tx_halt), .xoff_irq(xoff_irq), .spec_irq(spec_irq),
    .spec_status(spec_status), .status_clr(status_clr)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s ctrl=%b spec=%0b data=%h: actual %h expected %h",
               tag, flow_ctrl, spec_en, in_data, act, exp);
    end
  endtask

  function automatic string mode_tag(input logic [3:0] c);
    if (c[1:0] == 2'b00) return "R7";
    if (c[1:0] == 2'b10) return "R3";
    if (c[1:0] == 2'b01) return "R4";
    if (c == 4'b1011 || c == 4'b0111) return "R5";
    return "R6";
  endfunction

  // Drive at falling edge, check combinational outputs, cross one rising edge, check registers.
  task automatic step(input bit v, input logic [7:0] d, input bit rdy, input bit clr);
    bit off_m, on_m, sp, a, nxt_poff, nxt_pon;
    in_valid = v; in_data = d; out_ready = rdy; status_clr = clr;
    #1;
    off_m = 0; on_m = 0;
    case (mode_tag(flow_ctrl))
      "R3": begin off_m = (d == C_OFF1); on_m = (d == C_ON1); end
      "R4": begin off_m = (d == C_OFF2); on_m = (d == C_ON2); end
      "R5": begin off_m = (d == C_OFF1) || (d == C_OFF2); on_m = (d == C_ON1) || (d == C_ON2); end
      "R6": begin off_m = m_poff && (d == C_OFF2); on_m = m_pon && (d == C_ON2); end
      default: ;
    endcase
    a  = v && rdy;
    sp = spec_en && (d == C_OFF2);
    chk("R2", {7'd0, in_ready}, {7'd0, rdy});
    chk("R2", out_data, d);
    chk("R9", {7'd0, out_valid}, {7'd0, v && !(off_m || on_m)});
    chk(mode_tag(flow_ctrl), {7'd0, xoff_irq}, {7'd0, a && off_m});
    chk(!spec_en ? "R13" : (flow_ctrl[1:0] == 2'b01 ? "R11" : "R10"),
        {7'd0, spec_irq}, {7'd0, a && sp});
    // model update
    nxt_poff = m_poff; nxt_pon = m_pon;
    if (mode_tag(flow_ctrl) != "R6") begin nxt_poff = 0; nxt_pon = 0; end
    else if (a) begin nxt_poff = (d == C_OFF1); nxt_pon = (d == C_ON1); end
    m_poff = nxt_poff; m_pon = nxt_pon;
    if (flow_ctrl[1:0] == 2'b00) m_halt = 0;
    else if (a && off_m) m_halt = 1;
    else if (a && on_m) m_halt = 0;
    if (a && sp) m_stat = 1;
    else if (clr) m_stat = 0;
    @(negedge clk);
    chk("R8", {7'd0, tx_halt}, {7'd0, m_halt});
    chk("R12", {7'd0, spec_status}, {7'd0, m_stat});
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : stim
    logic [7:0] chars [5];
    chars[0] = C_ON1; chars[1] = C_ON2; chars[2] = C_OFF1; chars[3] = C_OFF2; chars[4] = C_OTH;
    repeat (3) @(negedge clk);
    chk("R1", {6'd0, tx_halt, spec_status}, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {6'd0, tx_halt, spec_status}, 8'd0);
    for (int s = 0; s < 2; s++) begin
      for (int c = 0; c < 16; c++) begin
        flow_ctrl = 4'(c); spec_en = s[0];
        for (int i = 0; i < 5; i++) begin
          for (int j = 0; j < 5; j++) begin
            int k = i * 5 + j;
            step(1'b1, chars[i], 1'b1, 1'b0);
            step(1'b1, chars[j], (k % 3) != 0, (k % 4) == 0);
            if ((k % 3) == 0) step(1'b1, chars[j], 1'b1, 1'b0);
            if ((k % 5) == 0) step(1'b0, C_OTH, 1'b1, 1'b0);
          end
        end
        // explicit sequences: pair, interrupted pair
        step(1'b1, C_OFF1, 1'b1, 1'b0); step(1'b1, C_OFF2, 1'b1, 1'b0);
        step(1'b1, C_ON1, 1'b1, 1'b0); step(1'b1, C_OTH, 1'b1, 1'b0);
        step(1'b1, C_ON2, 1'b1, 1'b1);
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule